// File: doc/BRIEF.md
# Line-Rate Double-Buffered Audio Sample Feeder

This block sends audio samples to a DAC at the video line rate. Each time the video timing logic signals the start of a scanline, the block reads one 12-bit sample from the buffer currently being played. The read address is that line's number within the frame. The sample goes to a registered DAC output together with a one-cycle valid pulse. The sample rate therefore equals the horizontal line rate, about 31.47 kHz for a 525-line, 60 Hz frame, and audio stays locked to video without a separate sample clock.

Storage is two equal sample buffers, each with one entry per line. One buffer is played while a producer fills the other through a simple write port. When the frame-end strobe arrives, after the last line's sample has gone out, the two buffers exchange roles. A new frame of audio therefore takes effect as a whole at a frame boundary. Every entry reads as mid-scale (2048) after reset until the producer writes it, so an idle output sits at the DAC's zero-signal level.

Top module: `scanline_audio_feeder`

## Requirements
- R1: `dac_valid_o` is high for exactly one cycle, the cycle after a clock edge at which `line_start_i` is high, and is low at all other times.
- R2: On that same edge, `dac_value_o` takes the sample stored at index `line_num_i` of the buffer being played, and holds it until the next line start.
- R3: Samples are 12-bit unsigned values. Every code from 0 to 4095, including both extremes, reaches `dac_value_o` unchanged.
- R4: Each pulse of `frame_end_i` exchanges the roles of the two buffers at that clock edge. A line start sampled at the same edge still reads the buffer that was played before the exchange.
- R5: A write (`wr_en_i` high) stores `wr_data_i` at `wr_addr_i` in the buffer that is not being played. The played buffer is unaffected, even when the write hits the address being read in the same cycle.
- R6: A write in the same cycle as `frame_end_i` lands in the buffer that becomes the played buffer after the exchange.
- R7: After reset, `dac_valid_o` is 0, `dac_value_o` is 2048, and every entry of both buffers reads 2048 until it is written.
- R8: A line number of 525 or more yields 2048. A write address of 525 or more is ignored and does not alias onto any stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle pulse at the start of each scanline |
| line_num_i | input | 10 | Scanline number within the frame, used as the read index |
| frame_end_i | input | 1 | One-cycle pulse after the last line; exchanges the buffer roles |
| wr_en_i | input | 1 | Producer write enable into the buffer not being played |
| wr_addr_i | input | 10 | Producer write index |
| wr_data_i | input | 12 | Producer sample value |
| dac_value_o | output | 12 | Registered sample sent to the DAC |
| dac_valid_o | output | 1 | One-cycle pulse marking a new DAC sample |

## Verification
The bench drives `line_start_i` and `frame_end_i` at the same edge to provoke the case where a sample read and a buffer exchange fall in the same cycle. The sample must come from the buffer that was played before the exchange, which the scoreboard predicts by updating its reference model in read-then-swap order. The same approach judges a producer write that coincides with the exchange or with a read of the same address: the write must land in the pre-exchange back buffer. This shows up only one frame later, when that buffer is played.

// File: rtl/afeed_pkg.sv
package afeed_pkg;

   // Number of sample buffers taking part in the ping-pong scheme
   localparam int unsigned NUM_BANKS = 2;

   // Mid-scale code for an unsigned sample of width w
   function automatic int unsigned mid_code(input int unsigned w);
      return 32'd1 << (w - 1);
   endfunction

endpackage

// File: rtl/afeed_bank.sv
// One sample buffer: a plain array plus a resettable per-entry written flag,
// so unwritten entries read as mid-scale without clearing the array.
module afeed_bank #(
   parameter int unsigned W     = 12,
   parameter int unsigned DEPTH = 525,
   parameter int unsigned AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam logic [W-1:0] MID = W'(afeed_pkg::mid_code(W));

   logic [W-1:0]     store [DEPTH];
   logic [DEPTH-1:0] filled;

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  filled        <= '0;
      else if (we) filled[waddr] <= 1'b1;
   end

   always_comb begin
      rdata = MID;
      if (int'(raddr) < DEPTH) begin
         if (filled[raddr]) rdata = store[raddr];
      end
   end
endmodule

// File: rtl/afeed_roles.sv
// Tracks which bank is played; toggles on every frame-end pulse.
module afeed_roles (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   output logic front_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         front_sel <= 1'b0;
      else if (frame_end) front_sel <= ~front_sel;
   end
endmodule

// File: rtl/afeed_outreg.sv
// DAC output register and valid pulse.
module afeed_outreg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] sample,
   output logic [W-1:0] value,
   output logic         valid
);
   localparam logic [W-1:0] MID = W'(afeed_pkg::mid_code(W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= MID;
         valid <= 1'b0;
      end else begin
         valid <= strobe;
         if (strobe) value <= sample;
      end
   end
endmodule

// File: rtl/scanline_audio_feeder.sv
module scanline_audio_feeder #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned LINES    = 525,
   parameter int unsigned LINE_AW  = $clog2(LINES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_start_i,
   input  logic [LINE_AW-1:0]  line_num_i,
   input  logic                frame_end_i,
   input  logic                wr_en_i,
   input  logic [LINE_AW-1:0]  wr_addr_i,
   input  logic [SAMPLE_W-1:0] wr_data_i,
   output logic [SAMPLE_W-1:0] dac_value_o,
   output logic                dac_valid_o
);
   localparam int unsigned NB = afeed_pkg::NUM_BANKS;

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("SAMPLE_W must be at least 2");
   end
   if (LINES > (1 << LINE_AW)) begin : g_bad_aw
      $error("LINE_AW too small for LINES");
   end

   logic                front_sel;
   logic                wr_ok;
   logic [SAMPLE_W-1:0] bank_rd [NB];
   logic [SAMPLE_W-1:0] cur_sample;

   assign wr_ok = wr_en_i && (int'(wr_addr_i) < LINES);

   afeed_roles i_roles (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end_i),
      .front_sel (front_sel)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_ok && (front_sel != 1'(b));
      afeed_bank #(.W(SAMPLE_W), .DEPTH(LINES), .AW(LINE_AW)) i_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bank_we),
         .waddr (wr_addr_i),
         .wdata (wr_data_i),
         .raddr (line_num_i),
         .rdata (bank_rd[b])
      );
   end

   assign cur_sample = bank_rd[front_sel];

   afeed_outreg #(.W(SAMPLE_W)) i_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (line_start_i),
      .sample (cur_sample),
      .value  (dac_value_o),
      .valid  (dac_valid_o)
   );
endmodule

// File: rtl/afeed_checker.sv
module afeed_checker #(
   parameter int unsigned W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         line_start_i,
   input logic         frame_end_i,
   input logic         front_sel,
   input logic [W-1:0] dac_value_o,
   input logic         dac_valid_o
);
   assert_valid_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_i |=> dac_valid_o);

   assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start_i |=> !dac_valid_o);

   assert_value_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start_i |=> $stable(dac_value_o));

   assert_swap_on_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_i |=> (front_sel != $past(front_sel)));

   assert_roles_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_i |=> $stable(front_sel));
endmodule

bind scanline_audio_feeder afeed_checker #(.W(SAMPLE_W)) i_afeed_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .line_start_i (line_start_i),
   .frame_end_i  (frame_end_i),
   .front_sel    (front_sel),
   .dac_value_o  (dac_value_o),
   .dac_valid_o  (dac_valid_o)
);

// File: tb/test_scanline_audio_feeder.sv
`timescale 1ns/1ps
module test_scanline_audio_feeder;
   localparam int L  = 525;
   localparam int MID = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_start_i = 1'b0;
   logic [9:0]  line_num_i = '0;
   logic        frame_end_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [9:0]  wr_addr_i = '0;
   logic [11:0] wr_data_i = '0;
   logic [11:0] dac_value_o;
   logic        dac_valid_o;

   int checks = 0;
   int fails  = 0;
   int model [2][L];
   int front = 0;
   int    exp_q [$];
   string tag_q [$];
   bit    done = 0;

   always #2 clk = ~clk;

   scanline_audio_feeder i_scanline_audio_feeder (.*);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Driver: one cycle of stimulus, model updated read-then-write-then-swap
   task automatic step(input bit ls, input int ln, input bit fe,
                       input bit we, input int wa, input int wd, input string req);
      line_start_i = ls; line_num_i = 10'(ln); frame_end_i = fe;
      wr_en_i = we; wr_addr_i = 10'(wa); wr_data_i = 12'(wd);
      if (ls) begin
         exp_q.push_back(ln < L ? model[front][ln] : MID);
         tag_q.push_back(req);
      end
      if (we && wa < L) model[1-front][wa] = wd;
      if (fe) front = 1 - front;
      @(negedge clk);
      line_start_i = 0; frame_end_i = 0; wr_en_i = 0;
   endtask

   task automatic play(input int ln, input string req);
      step(1, ln, 0, 0, 0, 0, req);
   endtask
   task automatic wr(input int wa, input int wd);
      step(0, 0, 0, 1, wa, wd, "");
   endtask
   task automatic swap();
      step(0, 0, 1, 0, 0, 0, "");
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && dac_valid_o) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected valid", 1, 0);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, int'(dac_value_o), e);
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < L; i++) model[b][i] = MID;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 reset value", int'(dac_value_o), MID);
      check("R7 reset valid", int'(dac_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle no valid", int'(dac_valid_o), 0);
      // R7: unwritten entries in both banks are mid-scale
      play(0, "R7 bank0 line0");
      play(524, "R7 bank0 line524");
      swap();
      play(7, "R7 bank1 line7");
      swap();
      // R5: fill back buffer, front stays mid-scale
      for (int i = 0; i < L; i++) wr(i, (i * 37 + 5) % 4096);
      play(10, "R5 front untouched");
      play(300, "R5 front untouched");
      // R3: extreme codes
      wr(1, 0);
      wr(2, 4095);
      // R4: swap then play new data
      swap();
      play(0, "R2 line0");
      play(1, "R3 zero code");
      play(2, "R3 full code");
      play(524, "R2 last line");
      for (int i = 100; i < 110; i++) play(i, "R2 sweep");
      // R2: value held between lines (checked by idle cycles then new line)
      repeat (3) @(negedge clk);
      check("R2 value held", int'(dac_value_o), model[front][109]);
      // R5: same-cycle write to same address in back, read front
      step(1, 50, 0, 1, 50, 777, "R5 same addr read");
      // R4: line start together with frame end reads pre-swap front
      step(1, 60, 1, 0, 0, 0, "R4 read before swap");
      play(50, "R5 write visible after swap");
      // R6: write with swap lands in new front
      step(0, 0, 1, 1, 70, 1234, "");
      play(70, "R6 write at swap");
      // R8: out-of-range line and write address
      step(0, 0, 0, 1, 600, 99, "");
      swap();
      play(600, "R8 line out of range");
      play(88, "R8 no alias");
      play(600 - 512, "R8 no alias low");
      repeat (3) @(negedge clk);
      check("R1 queue drained", exp_q.size(), 0);
      done = 1;
      finish_run();
   end
endmodule